// File: doc/BRIEF.md
# Interrupt Status and Event Register Block

This block is a small set of peripheral registers on a 32-bit memory-mapped bus. It gathers single-cycle event inputs into a sticky status register: a received byte, a transmitter ready indication, an address translation fault, and the two phases of one tap bit of an internal free-running counter. A mask register selects which status bits may raise the interrupt request line to the CPU.

Alongside the status and mask registers the block holds a serial data port (the last received byte for reads, a byte strobe to the transmitter for writes), a process identifier register that is driven out to the translation unit, and a read-only fault page register. The fault page register is loaded when the translation unit reports a fault. Accesses have side effects. A read of the data port consumes the receive flag. A write into the translation-table window, or a clear pulse from the translation unit, drops the fault flag. A status write replaces the whole register. When an event arrives in the same cycle as a clear, the event is kept.

Read data is combinational from the current register state, so it is valid in the same cycle as the access. Every side effect of the access takes hold on the clock edge that closes that cycle.

Top module: `irq_event_regs`

## Requirements
- R1: While reset is low, the status, mask, process identifier and fault page registers all read as zero, `irq` is low and `tx_strobe` is low.
- R2: A write to the data port at offset 0x00 pulses `tx_strobe` high for exactly the one cycle after the write edge, with `tx_data` equal to bits 7:0 of the written word.
- R3: A read of the data port returns the last byte presented with `rx_valid`, zero-extended. At that edge it clears status bit 0.
- R4: The mask register at offset 0x10 holds 10 bits and reads back what was written to bits 9:0. Bits 31:10 read as zero.
- R5: A write to the status register at offset 0x20 replaces all 10 status bits with bits 9:0 of the written word. Bits above 9 are dropped.
- R6: Status bit 0 is set by `rx_valid`, bit 1 by `tx_ready`, and bit 9 by `mmu_fault`, each at the clock edge where the input is high.
- R7: At every edge, status bit 3 is set when the counter tap bit is 1 and status bit 2 is set when the tap bit is 0. The counter starts at zero after reset and counts every cycle.
- R8: `irq` is high exactly when some status bit and its mask bit are both 1.
- R9: A write to the configuration offset 0x70 changes no register.
- R10: The process identifier register at offset 0x80 is a full 32-bit read/write register and drives the `pid` output.
- R11: The fault page register at offset 0x90 is loaded on `mmu_fault` with `mmu_fault_addr` with its low PAGE_W bits cleared. Bus writes to it are ignored.
- R12: A write anywhere in the translation-table window (offset 0xA0 up to, but not including, 0xA0 + 8·TLB_ENTRIES) raises `tlb_we` in that cycle with `tlb_idx` equal to the 32-bit word index in the window, and clears status bit 9. So does a `mmu_clr` pulse. A write just past the window does neither.
- R13: When a set event and a clear of the same status bit happen at the same edge (data read, window write, `mmu_clr` or status write), the bit ends up set.
- R14: Reads of unmapped offsets, of the configuration offset and of the window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | Received byte event |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can accept a byte |
| tx_data | output | 8 | Byte for the transmitter |
| tx_strobe | output | 1 | One-cycle send strobe |
| mmu_fault | input | 1 | Translation fault event |
| mmu_fault_addr | input | 32 | Faulting address |
| mmu_clr | input | 1 | Fault flag clear pulse |
| tlb_we | output | 1 | Write into the translation-table window |
| tlb_idx | output | TLB_IW | Word index inside the window |
| pid | output | 32 | Process identifier |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume at most one bus access per cycle. They also assume that event inputs are synchronous and sampled only at the clock edge, and that a mask write does not coincide with a fault event the interrupt check relies on. The bench keeps within this by driving every input on the falling edge and issuing bus accesses one at a time. It keeps deliberate coincidences of an event and a clear to the collision cases of R13. It lowers the counter tap to bit 4, so both counter phases reach the status register many times within a short run.

// File: rtl/irqev_pkg.sv
`timescale 1ns/1ps
package irqev_pkg;
  localparam int BUS_W = 32;
  localparam int ST_W  = 10;

  localparam int ST_RX     = 0;
  localparam int ST_TX     = 1;
  localparam int ST_TICK_N = 2;
  localparam int ST_TICK   = 3;
  localparam int ST_MMU    = 9;

  localparam logic [BUS_W-1:0] OFF_DATA  = 32'h0000_0000;
  localparam logic [BUS_W-1:0] OFF_MASK  = 32'h0000_0010;
  localparam logic [BUS_W-1:0] OFF_STAT  = 32'h0000_0020;
  localparam logic [BUS_W-1:0] OFF_CFG   = 32'h0000_0070;
  localparam logic [BUS_W-1:0] OFF_PID   = 32'h0000_0080;
  localparam logic [BUS_W-1:0] OFF_FAULT = 32'h0000_0090;
  localparam logic [BUS_W-1:0] OFF_TLB   = 32'h0000_00A0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA, SEL_MASK, SEL_STAT,
    SEL_CFG, SEL_PID, SEL_FAULT, SEL_TLB
  } reg_sel_e;

  // Software write first, then clears, then event sets: sets always win.
  function automatic logic [ST_W-1:0] status_next(
    input logic [ST_W-1:0] cur,
    input logic            wr_en,
    input logic [ST_W-1:0] wr_val,
    input logic [ST_W-1:0] clr,
    input logic [ST_W-1:0] set
  );
    logic [ST_W-1:0] base;
    base = wr_en ? wr_val : cur;
    return (base & ~clr) | set;
  endfunction

  function automatic logic [BUS_W-1:0] page_base(
    input logic [BUS_W-1:0] a,
    input int               pw
  );
    logic [BUS_W-1:0] keep;
    keep = '1;
    keep = keep << pw;
    return a & keep;
  endfunction
endpackage

// File: rtl/irqev_decode.sv
`timescale 1ns/1ps
module irqev_decode
  import irqev_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h2000_0000,
  parameter int          TLB_ENTRIES = 4,
  localparam int         TLB_WORDS   = TLB_ENTRIES * 2,
  localparam int         TLB_IW      = (TLB_WORDS > 1) ? $clog2(TLB_WORDS) : 1
) (
  input  logic              bus_sel,
  input  logic [BUS_W-1:0]  bus_addr,
  output reg_sel_e          hit,
  output logic [TLB_IW-1:0] tlb_idx
);
  localparam logic [BUS_W-1:0] TLB_SPAN = BUS_W'(TLB_WORDS * 4);

  logic [BUS_W-1:0] off;
  logic [BUS_W-1:0] tlb_off;

  assign off     = bus_addr - BASE_ADDR;
  assign tlb_off = off - OFF_TLB;

  always_comb begin
    hit     = SEL_NONE;
    tlb_idx = '0;
    if (bus_sel) begin
      if (off == OFF_DATA)       hit = SEL_DATA;
      else if (off == OFF_MASK)  hit = SEL_MASK;
      else if (off == OFF_STAT)  hit = SEL_STAT;
      else if (off == OFF_CFG)   hit = SEL_CFG;
      else if (off == OFF_PID)   hit = SEL_PID;
      else if (off == OFF_FAULT) hit = SEL_FAULT;
      else if (off >= OFF_TLB && tlb_off < TLB_SPAN) begin
        hit     = SEL_TLB;
        tlb_idx = tlb_off[TLB_IW+1:2];
      end
    end
  end
endmodule

// File: rtl/irqev_status.sv
`timescale 1ns/1ps
module irqev_status
  import irqev_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_val,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr_vec,
  output logic [ST_W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_next(status_q, wr_en, wr_val, clr_vec, set_vec);
  end
endmodule

// File: rtl/irqev_ticker.sv
`timescale 1ns/1ps
module irqev_ticker #(
  parameter int CNT_W   = 32,
  parameter int CNT_TAP = 18
) (
  input  logic clk,
  input  logic rst_n,
  output logic tap
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign tap = cnt_q[CNT_TAP];
endmodule

// File: rtl/irq_event_regs.sv
`timescale 1ns/1ps
module irq_event_regs
  import irqev_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h2000_0000,
  parameter int          TLB_ENTRIES = 4,
  parameter int          CNT_W       = 32,
  parameter int          CNT_TAP     = 18,
  parameter int          PAGE_W      = 12,
  localparam int         TLB_IW      = (TLB_ENTRIES * 2 > 1) ? $clog2(TLB_ENTRIES * 2) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_strobe,
  input  logic              mmu_fault,
  input  logic [31:0]       mmu_fault_addr,
  input  logic              mmu_clr,
  output logic              tlb_we,
  output logic [TLB_IW-1:0] tlb_idx,
  output logic [31:0]       pid,
  output logic              irq
);
  reg_sel_e        hit;
  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] mask_q;
  logic [31:0]     pid_q;
  logic [31:0]     fault_q;
  logic [7:0]      rx_q;
  logic [7:0]      tx_data_q;
  logic            tx_strobe_q;
  logic            cnt_tap;
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] clr_vec;

  // Named access events, shared with the checker.
  logic data_rd_ev, data_wr_ev, mask_wr_ev, stat_wr_ev;
  logic cfg_wr_ev, pid_wr_ev, tlb_wr_ev;

  irqev_decode #(
    .BASE_ADDR   (BASE_ADDR),
    .TLB_ENTRIES (TLB_ENTRIES)
  ) decode_i (
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .hit      (hit),
    .tlb_idx  (tlb_idx)
  );

  assign data_rd_ev = (hit == SEL_DATA) && !bus_we;
  assign data_wr_ev = (hit == SEL_DATA) &&  bus_we;
  assign mask_wr_ev = (hit == SEL_MASK) &&  bus_we;
  assign stat_wr_ev = (hit == SEL_STAT) &&  bus_we;
  assign cfg_wr_ev  = (hit == SEL_CFG)  &&  bus_we;
  assign pid_wr_ev  = (hit == SEL_PID)  &&  bus_we;
  assign tlb_wr_ev  = (hit == SEL_TLB)  &&  bus_we;

  irqev_ticker #(
    .CNT_W   (CNT_W),
    .CNT_TAP (CNT_TAP)
  ) ticker_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tap   (cnt_tap)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_RX]     = rx_valid;
    set_vec[ST_TX]     = tx_ready;
    set_vec[ST_TICK_N] = !cnt_tap;
    set_vec[ST_TICK]   = cnt_tap;
    set_vec[ST_MMU]    = mmu_fault;
    clr_vec            = '0;
    clr_vec[ST_RX]     = data_rd_ev;
    clr_vec[ST_MMU]    = tlb_wr_ev | mmu_clr;
  end

  irqev_status status_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (stat_wr_ev),
    .wr_val   (bus_wdata[ST_W-1:0]),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      pid_q       <= '0;
      fault_q     <= '0;
      rx_q        <= '0;
      tx_data_q   <= '0;
      tx_strobe_q <= 1'b0;
    end else begin
      tx_strobe_q <= data_wr_ev;
      if (data_wr_ev) tx_data_q <= bus_wdata[7:0];
      if (mask_wr_ev) mask_q    <= bus_wdata[ST_W-1:0];
      if (pid_wr_ev)  pid_q     <= bus_wdata;
      if (rx_valid)   rx_q      <= rx_byte;
      if (mmu_fault)  fault_q   <= page_base(mmu_fault_addr, PAGE_W);
    end
  end

  always_comb begin
    case (hit)
      SEL_DATA:  bus_rdata = {24'h0, rx_q};
      SEL_MASK:  bus_rdata = {{(32-ST_W){1'b0}}, mask_q};
      SEL_STAT:  bus_rdata = {{(32-ST_W){1'b0}}, status_q};
      SEL_PID:   bus_rdata = pid_q;
      SEL_FAULT: bus_rdata = fault_q;
      default:   bus_rdata = '0;
    endcase
    if (bus_we) bus_rdata = '0;
  end

  assign tx_data   = tx_data_q;
  assign tx_strobe = tx_strobe_q;
  assign tlb_we    = tlb_wr_ev;
  assign pid       = pid_q;
  assign irq       = |(status_q & mask_q);
endmodule

// File: rtl/irqev_chk.sv
`timescale 1ns/1ps
module irqev_chk
  import irqev_pkg::*;
#(
  parameter int PAGE_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ST_W-1:0] status_q,
  input logic [ST_W-1:0] mask_q,
  input logic [31:0]     pid_q,
  input logic [31:0]     fault_q,
  input logic            cnt_tap,
  input logic            rx_valid,
  input logic            mmu_fault,
  input logic [31:0]     mmu_fault_addr,
  input logic            mmu_clr,
  input logic            data_rd_ev,
  input logic            data_wr_ev,
  input logic            mask_wr_ev,
  input logic            tlb_wr_ev,
  input logic            cfg_wr_ev,
  input logic [31:0]     bus_wdata,
  input logic            tx_strobe,
  input logic [7:0]      tx_data,
  input logic            irq
);
  // R2
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev |=> (tx_strobe && tx_data == $past(bus_wdata[7:0])));

  // R3
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_ev && !rx_valid) |=> !status_q[ST_RX]);

  // R7
  tick_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tap |=> status_q[ST_TICK]);

  // R7
  tick_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tap |=> status_q[ST_TICK_N]);

  // R8
  irq_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_fault && mask_q[ST_MMU] && !mask_wr_ev) |=> irq);

  // R9
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_ev |=> ($stable(mask_q) && $stable(pid_q)));

  // R11
  fault_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_fault |=> (fault_q == page_base($past(mmu_fault_addr), PAGE_W)));

  // R12
  tlb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tlb_wr_ev || mmu_clr) && !mmu_fault) |=> !status_q[ST_MMU]);

  // R13
  rx_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> status_q[ST_RX]);

  // R13
  fault_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_fault |=> status_q[ST_MMU]);
endmodule

bind irq_event_regs irqev_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .status_q       (status_q),
  .mask_q         (mask_q),
  .pid_q          (pid_q),
  .fault_q        (fault_q),
  .cnt_tap        (cnt_tap),
  .rx_valid       (rx_valid),
  .mmu_fault      (mmu_fault),
  .mmu_fault_addr (mmu_fault_addr),
  .mmu_clr        (mmu_clr),
  .data_rd_ev     (data_rd_ev),
  .data_wr_ev     (data_wr_ev),
  .mask_wr_ev     (mask_wr_ev),
  .tlb_wr_ev      (tlb_wr_ev),
  .cfg_wr_ev      (cfg_wr_ev),
  .bus_wdata      (bus_wdata),
  .tx_strobe      (tx_strobe),
  .tx_data        (tx_data),
  .irq            (irq)
);

// File: tb/irq_event_regs_tb_top.sv
`timescale 1ns/1ps
module irq_event_regs_tb_top;
  localparam int          TAP  = 4;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam logic [31:0] A_DATA  = BASE + 32'h00;
  localparam logic [31:0] A_MASK  = BASE + 32'h10;
  localparam logic [31:0] A_STAT  = BASE + 32'h20;
  localparam logic [31:0] A_CFG   = BASE + 32'h70;
  localparam logic [31:0] A_PID   = BASE + 32'h80;
  localparam logic [31:0] A_FAULT = BASE + 32'h90;
  localparam logic [31:0] A_TLB   = BASE + 32'hA0;
  localparam logic [31:0] NO_TICK = 32'hFFFF_FFF3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  tx_data;
  logic        tx_strobe;
  logic        mmu_fault = 1'b0, mmu_clr = 1'b0;
  logic [31:0] mmu_fault_addr = '0;
  logic        tlb_we;
  logic [2:0]  tlb_idx;
  logic [31:0] pid;
  logic        irq;

  irq_event_regs #(
    .BASE_ADDR (BASE),
    .CNT_TAP   (TAP)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rx_valid (rx_valid), .rx_byte (rx_byte), .tx_ready (tx_ready),
    .tx_data (tx_data), .tx_strobe (tx_strobe),
    .mmu_fault (mmu_fault), .mmu_fault_addr (mmu_fault_addr), .mmu_clr (mmu_clr),
    .tlb_we (tlb_we), .tlb_idx (tlb_idx), .pid (pid), .irq (irq)
  );

  // Cycle count since reset release, from the counter requirement (R7).
  logic [31:0] mcnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mcnt <= '0;
    else        mcnt <= mcnt + 1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Write, then read in the very next cycle; also returns the model count.
  task automatic wr_then_rd(input logic [31:0] a, input logic [31:0] d,
                            input logic [31:0] ra, output logic [31:0] v,
                            output logic [31:0] m);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ra;
    #1 v = bus_rdata; m = mcnt;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, A_MASK,  32'hFFFF_FFFF, 32'h0,         4'd4 },  // R4 write
    '{1'b0, A_MASK,  32'h0,         32'h0000_03FF, 4'd4 },  // R4 only 10 bits kept
    '{1'b1, A_PID,   32'hCAFE_0123, 32'h0,         4'd10},  // R10 write
    '{1'b0, A_PID,   32'h0,         32'hCAFE_0123, 4'd10},  // R10 read back
    '{1'b1, A_CFG,   32'h1234_5678, 32'h0,         4'd9 },  // R9 config write
    '{1'b0, A_PID,   32'h0,         32'hCAFE_0123, 4'd9 },  // R9 pid unchanged
    '{1'b0, A_MASK,  32'h0,         32'h0000_03FF, 4'd9 },  // R9 mask unchanged
    '{1'b0, A_CFG,   32'h0,         32'h0,         4'd14},  // R14 config reads zero
    '{1'b0, BASE + 32'h40, 32'h0,   32'h0,         4'd14},  // R14 unmapped
    '{1'b0, A_TLB,   32'h0,         32'h0,         4'd14},  // R14 window reads zero
    '{1'b1, A_FAULT, 32'hFFFF_FFFF, 32'h0,         4'd11},  // R11 write ignored
    '{1'b0, A_FAULT, 32'h0,         32'h0,         4'd11},  // R11 still zero
    '{1'b1, A_MASK,  32'h0000_0200, 32'h0,         4'd4 },  // R4 fault-only mask
    '{1'b0, A_MASK,  32'h0,         32'h0000_0200, 4'd4 }   // R4 read back
  };

  initial begin
    logic [31:0] v, m, t;
    // R1: reset state, read combinationally while reset is held.
    repeat (2) @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0;
    bus_addr = A_STAT;  #1 chk("R1 status in reset", bus_rdata, 32'h0);
    bus_addr = A_MASK;  #1 chk("R1 mask in reset", bus_rdata, 32'h0);
    bus_addr = A_PID;   #1 chk("R1 pid in reset", bus_rdata, 32'h0);
    bus_addr = A_FAULT; #1 chk("R1 fault in reset", bus_rdata, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 tx_strobe in reset", {31'h0, tx_strobe}, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_wr(VECS[i].addr, VECS[i].wdata);
      else begin
        bus_rd(VECS[i].addr, v);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end
    chk("R10 pid output", pid, 32'hCAFE_0123);

    // R2: transmit strobe one cycle.
    bus_wr(A_DATA, 32'h0000_01A5);
    chk("R2 strobe high", {31'h0, tx_strobe}, 32'h1);
    chk("R2 tx byte", {24'h0, tx_data}, 32'h0000_00A5);
    @(negedge clk);
    chk("R2 strobe single cycle", {31'h0, tx_strobe}, 32'h0);

    // R6 / R3: receive path.
    bus_wr(A_STAT, 32'h0);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h3C;
    @(negedge clk); rx_valid = 1'b0;
    bus_rd(A_STAT, v); chk("R6 rx sets bit0", v & 32'h1, 32'h1);
    bus_rd(A_DATA, v); chk("R3 data read byte", v, 32'h0000_003C);
    bus_rd(A_STAT, v); chk("R3 read clears bit0", v & 32'h1, 32'h0);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    bus_rd(A_STAT, v); chk("R6 tx_ready sets bit1", v & 32'h2, 32'h2);

    // R5 / R8: status write replaces contents.
    wr_then_rd(A_STAT, 32'h0000_0201, A_STAT, v, m);
    chk("R5 status replaced", v & NO_TICK, 32'h0000_0201);
    chk("R8 irq on masked bit9", {31'h0, irq}, 32'h1);
    wr_then_rd(A_STAT, 32'hFFFF_FC00, A_STAT, v, m);
    chk("R5 high bits dropped, bit1 cleared", v & NO_TICK, 32'h0);
    chk("R8 irq low", {31'h0, irq}, 32'h0);

    // R7: counter tap phases.
    for (int k = 0; k < 8; k++) begin
      wr_then_rd(A_STAT, 32'h0, A_STAT, v, m);
      t = ((m - 1) >> TAP) & 32'h1;
      chk("R7 tick bits", v & 32'hC, (t != 0) ? 32'h8 : 32'h4);
      repeat (3) @(negedge clk);
    end

    // R11 / R8: fault capture.
    @(negedge clk); mmu_fault = 1'b1; mmu_fault_addr = 32'h1234_5ABC;
    @(negedge clk); mmu_fault = 1'b0;
    chk("R8 irq from fault", {31'h0, irq}, 32'h1);
    bus_rd(A_FAULT, v); chk("R11 fault page", v, 32'h1234_5000);
    bus_rd(A_STAT, v);  chk("R6 fault sets bit9", v & 32'h200, 32'h200);

    // R12: window write clears fault flag.
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_TLB + 32'h8; bus_wdata = 32'h55;
    #1 chk("R12 tlb_we", {31'h0, tlb_we}, 32'h1);
    chk("R12 tlb_idx", {29'h0, tlb_idx}, 32'h2);
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    chk("R12 irq dropped", {31'h0, irq}, 32'h0);
    bus_rd(A_STAT, v); chk("R12 bit9 cleared", v & 32'h200, 32'h0);

    @(negedge clk); mmu_fault = 1'b1;
    @(negedge clk); mmu_fault = 1'b0;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_TLB + 32'h20; bus_wdata = 32'h0;
    #1 chk("R12 past window no tlb_we", {31'h0, tlb_we}, 32'h0);
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    bus_rd(A_STAT, v); chk("R12 past window keeps bit9", v & 32'h200, 32'h200);
    @(negedge clk); mmu_clr = 1'b1;
    @(negedge clk); mmu_clr = 1'b0;
    bus_rd(A_STAT, v); chk("R12 mmu_clr clears bit9", v & 32'h200, 32'h0);

    // R13: set wins over clear.
    @(negedge clk);
    mmu_fault = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_TLB; bus_wdata = 32'h0;
    @(negedge clk); mmu_fault = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_rd(A_STAT, v); chk("R13 fault beats window write", v & 32'h200, 32'h200);

    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h77;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_DATA;
    #1 chk("R13 read returns older byte", bus_rdata, 32'h0000_003C);
    @(negedge clk); rx_valid = 1'b0; bus_sel = 1'b0;
    bus_rd(A_STAT, v); chk("R13 rx beats data read", v & 32'h1, 32'h1);
    bus_rd(A_DATA, v); chk("R3 new byte", v, 32'h0000_0077);

    @(negedge clk);
    mmu_fault = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0;
    @(negedge clk); mmu_fault = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_rd(A_STAT, v); chk("R13 fault beats status write", v & 32'h201, 32'h200);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule